// File: doc/BRIEF.md
# Planar Video Memory Read Path

This block serves host byte reads from a video memory organised as four byte-wide planes packed into 32-bit words. Each request carries a host byte address and a snapshot of the addressing and read-mode controls. The block picks a source plane, converts the byte address into a word index according to the active addressing scheme, and issues a single word read to a synchronous memory that lives outside the block.

One cycle after the request it returns either the selected plane's byte or an 8-bit colour-compare vector, flagged by a read-valid strobe. Every planar, non-packed read also captures the whole 32-bit word in a read latch. The latch is exported so that a write datapath can merge latched pixels back into memory.

A word index beyond the memory size produces 0xFF with no memory access and no latch change.

Top module: `vplane_rd`

## Requirements
- R1: With packed-pixel mode on (`cfg_packed`=1), the plane is host address bits [1:0] and those two bits are cleared before any shifting.
- R2: With packed-pixel mode off and host odd/even on (`cfg_host_oe`=1), the plane is {`cfg_map_sel`[1], host address bit 0}.
- R3: With both packed-pixel mode and host odd/even off, the plane equals `cfg_map_sel`.
- R4: With `cfg_pair_clr`=1, address bit 0 is cleared after plane selection and before shifting.
- R5: With `cfg_dword`=1 the address shifts right by 2. Otherwise, when `cfg_host_oe`=1 and `cfg_byte_mode`=0, it shifts right by 1. Otherwise it is not shifted.
- R6: If the resulting word index is not below MEM_WORDS, `mem_rd_en` stays low, `rd_data` is 0xFF and `latch_q` is unchanged.
- R7: In packed-pixel mode the returned byte is lane `plane` of the addressed word, whatever the read mode, and `latch_q` is not loaded.
- R8: Any in-range read outside packed-pixel mode loads `latch_q` with the addressed word. The new value is visible one cycle after `rd_valid`.
- R9: Plane p occupies bits 8p+7:8p of a memory word. In read mode 0 (`cfg_cmp_mode`=0) the byte of the selected plane is returned.
- R10: In read mode 1 (`cfg_cmp_mode`=1) each plane byte is XORed with {8{`cfg_cmp_val`[p]}} and ANDed with {8{`cfg_cmp_care`[p]}}. The four results are ORed together and inverted, so a bit is 1 where the pixel matches. All care bits 0 gives 0xFF.
- R11: `rd_valid` is high exactly in the cycle after each cycle with `host_req` high, and `rd_data` is valid in that cycle. Back-to-back requests are accepted every cycle.
- R12: After synchronous reset `rd_valid` is 0 and `latch_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host read request, one per cycle |
| host_addr | input | HOST_AW | Host byte address |
| cfg_packed | input | 1 | Packed-pixel (four planes interleaved per byte) addressing |
| cfg_host_oe | input | 1 | Host odd/even plane selection |
| cfg_pair_clr | input | 1 | Clear address bit 0 (chained odd/even) |
| cfg_dword | input | 1 | Doubleword address shift |
| cfg_byte_mode | input | 1 | 1 = byte addressing, 0 = word shift under host odd/even |
| cfg_cmp_mode | input | 1 | Read mode: 0 plane byte, 1 colour compare |
| cfg_map_sel | input | 2 | Read plane select |
| cfg_cmp_val | input | 4 | Colour compare value, one bit per plane |
| cfg_cmp_care | input | 4 | Colour compare care mask, one bit per plane |
| mem_rd_en | output | 1 | Word read strobe to synchronous memory |
| mem_addr | output | MEM_AW | Word index to memory |
| mem_rdata | input | 32 | Word returned by memory one cycle after `mem_rd_en` |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |
| latch_q | output | 32 | Read latch for the write datapath |

## Verification
The two functions that meet in one cycle are the latch load of one read and the completion of the next read. With requests issued back to back, the cycle that returns request N+1's byte is also the edge where request N's word lands in the latch. A packed-pixel or out-of-range request placed straight after a planar read must leave the latch as that read set it. The bench drives streams of mixed modes and addresses every cycle. Its behavioural model tracks when the latch should change, and the bench compares the model against `rd_valid`, `rd_data` and `latch_q` on every clock.

// File: rtl/vprd_pkg.sv
package vprd_pkg;
  localparam int PLANES = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = PLANES * LANE_W;
  localparam int PSEL_W = $clog2(PLANES);

  typedef logic [PSEL_W-1:0] plane_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic              packed_px;
    logic              host_oe;
    logic              pair_clr;
    logic              dword;
    logic              byte_mode;
    logic              cmp_mode;
    plane_t            map_sel;
    logic [PLANES-1:0] cmp_val;
    logic [PLANES-1:0] cmp_care;
  } rd_cfg_t;
endpackage

// File: rtl/vprd_addr_map.sv
module vprd_addr_map
  import vprd_pkg::*;
#(
  parameter int HOST_AW   = 18,
  parameter int MEM_WORDS = 16384
) (
  input  logic [HOST_AW-1:0] host_addr,
  input  rd_cfg_t            cfg,
  output plane_t             plane,
  output logic [HOST_AW-1:0] word_idx,
  output logic               in_range
);
  localparam logic [HOST_AW:0] LIMIT = (HOST_AW + 1)'(MEM_WORDS);

  logic [HOST_AW-1:0] a_sel;
  logic [HOST_AW-1:0] a_pair;

  // plane choice: packed pixel wins over host odd/even
  always_comb begin
    a_sel = host_addr;
    if (cfg.packed_px) begin
      plane      = host_addr[1:0];
      a_sel[1:0] = 2'b00;
    end else if (cfg.host_oe) begin
      plane = {cfg.map_sel[1], host_addr[0]};
    end else begin
      plane = cfg.map_sel;
    end
  end

  always_comb begin
    a_pair = a_sel;
    if (cfg.pair_clr) a_pair[0] = 1'b0;
  end

  // doubleword shift takes priority over word shift
  always_comb begin
    if (cfg.dword)
      word_idx = a_pair >> 2;
    else if (cfg.host_oe && !cfg.byte_mode)
      word_idx = a_pair >> 1;
    else
      word_idx = a_pair;
  end

  assign in_range = ({1'b0, word_idx} < LIMIT);
endmodule

// File: rtl/vprd_lane_sel.sv
module vprd_lane_sel
  import vprd_pkg::*;
(
  input  word_t  word,
  input  plane_t plane,
  output lane_t  lane
);
  lane_t lanes [PLANES];

  for (genvar p = 0; p < PLANES; p++) begin : g_lane
    assign lanes[p] = word[p*LANE_W +: LANE_W];
  end

  assign lane = lanes[plane];
endmodule

// File: rtl/vprd_cmp_reduce.sv
module vprd_cmp_reduce
  import vprd_pkg::*;
(
  input  word_t             word,
  input  logic [PLANES-1:0] cmp_val,
  input  logic [PLANES-1:0] cmp_care,
  output lane_t             match
);
  lane_t diff [PLANES];

  for (genvar p = 0; p < PLANES; p++) begin : g_diff
    assign diff[p] = (word[p*LANE_W +: LANE_W] ^ {LANE_W{cmp_val[p]}})
                     & {LANE_W{cmp_care[p]}};
  end

  always_comb begin
    lane_t any_diff;
    any_diff = '0;
    for (int p = 0; p < PLANES; p++) any_diff = any_diff | diff[p];
    match = ~any_diff;
  end
endmodule

// File: rtl/vplane_rd.sv
module vplane_rd
  import vprd_pkg::*;
#(
  parameter int HOST_AW   = 18,
  parameter int MEM_WORDS = 16384,
  localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               cfg_packed,
  input  logic               cfg_host_oe,
  input  logic               cfg_pair_clr,
  input  logic               cfg_dword,
  input  logic               cfg_byte_mode,
  input  logic               cfg_cmp_mode,
  input  logic [1:0]         cfg_map_sel,
  input  logic [3:0]         cfg_cmp_val,
  input  logic [3:0]         cfg_cmp_care,
  output logic               mem_rd_en,
  output logic [MEM_AW-1:0]  mem_addr,
  input  logic [31:0]        mem_rdata,
  output logic               rd_valid,
  output logic [7:0]         rd_data,
  output logic [31:0]        latch_q
);
  rd_cfg_t            cfg;
  plane_t             plane;
  logic [HOST_AW-1:0] word_idx;
  logic               in_range;

  assign cfg = '{packed_px: cfg_packed, host_oe: cfg_host_oe,
                 pair_clr: cfg_pair_clr, dword: cfg_dword,
                 byte_mode: cfg_byte_mode, cmp_mode: cfg_cmp_mode,
                 map_sel: cfg_map_sel, cmp_val: cfg_cmp_val,
                 cmp_care: cfg_cmp_care};

  vprd_addr_map #(.HOST_AW(HOST_AW), .MEM_WORDS(MEM_WORDS)) i_map (
    .host_addr (host_addr),
    .cfg       (cfg),
    .plane     (plane),
    .word_idx  (word_idx),
    .in_range  (in_range)
  );

  assign mem_rd_en = host_req && in_range;
  assign mem_addr  = word_idx[MEM_AW-1:0];

  // stage register: context of the read whose word arrives next cycle
  logic              st_valid;
  logic              st_hit;
  logic              st_packed;
  logic              st_cmp;
  plane_t            st_plane;
  logic [PLANES-1:0] st_val;
  logic [PLANES-1:0] st_care;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid  <= 1'b0;
      st_hit    <= 1'b0;
      st_packed <= 1'b0;
      st_cmp    <= 1'b0;
      st_plane  <= '0;
      st_val    <= '0;
      st_care   <= '0;
    end else begin
      st_valid  <= host_req;
      st_hit    <= host_req && in_range;
      st_packed <= cfg.packed_px;
      st_cmp    <= cfg.cmp_mode;
      st_plane  <= plane;
      st_val    <= cfg.cmp_val;
      st_care   <= cfg.cmp_care;
    end
  end

  lane_t plane_byte;
  lane_t cmp_byte;

  vprd_lane_sel i_lane (
    .word  (mem_rdata),
    .plane (st_plane),
    .lane  (plane_byte)
  );

  vprd_cmp_reduce i_cmp (
    .word     (mem_rdata),
    .cmp_val  (st_val),
    .cmp_care (st_care),
    .match    (cmp_byte)
  );

  always_comb begin
    if (!st_hit)
      rd_data = 8'hFF;
    else if (st_packed || !st_cmp)
      rd_data = plane_byte;
    else
      rd_data = cmp_byte;
  end

  assign rd_valid = st_valid;

  always_ff @(posedge clk) begin
    if (rst)
      latch_q <= '0;
    else if (st_valid && st_hit && !st_packed)
      latch_q <= mem_rdata;
  end
endmodule

// File: rtl/vprd_rd_checker.sv
module vprd_rd_checker #(
  parameter int MEM_AW = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              host_req,
  input logic              cfg_packed,
  input logic              cfg_cmp_mode,
  input logic [3:0]        cfg_cmp_care,
  input logic              mem_rd_en,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [31:0]       mem_rdata,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic [31:0]       latch_q
);
  p_valid_after_req_r11: assert property (@(posedge clk) disable iff (rst)
    host_req |=> rd_valid);

  p_no_spurious_valid_r11: assert property (@(posedge clk) disable iff (rst)
    !host_req |=> !rd_valid);

  p_read_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> host_req);

  p_miss_returns_ff_r6: assert property (@(posedge clk) disable iff (rst)
    (host_req && !mem_rd_en) |=> (rd_data == 8'hFF));

  p_miss_keeps_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (host_req && !mem_rd_en) |-> ##2 $stable(latch_q));

  p_packed_keeps_latch_r7: assert property (@(posedge clk) disable iff (rst)
    (host_req && cfg_packed) |-> ##2 $stable(latch_q));

  p_latch_loads_word_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !cfg_packed) |-> ##2 (latch_q == $past(mem_rdata)));

  p_no_care_all_match_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !cfg_packed && cfg_cmp_mode && cfg_cmp_care == 4'h0)
      |=> (rd_data == 8'hFF));
endmodule

bind vplane_rd vprd_rd_checker #(.MEM_AW(MEM_AW)) i_rd_checker (
  .clk          (clk),
  .rst          (rst),
  .host_req     (host_req),
  .cfg_packed   (cfg_packed),
  .cfg_cmp_mode (cfg_cmp_mode),
  .cfg_cmp_care (cfg_cmp_care),
  .mem_rd_en    (mem_rd_en),
  .mem_addr     (mem_addr),
  .mem_rdata    (mem_rdata),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .latch_q      (latch_q)
);

// File: tb/test_vplane_rd.sv
`timescale 1ns/1ps
module test_vplane_rd;
  localparam int HAW   = 14;
  localparam int WORDS = 1024;
  localparam int MAW   = $clog2(WORDS);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            host_req = 1'b0;
  logic [HAW-1:0]  host_addr = '0;
  logic [15:0]     cfg = '0;
  logic            mem_rd_en;
  logic [MAW-1:0]  mem_addr;
  logic [31:0]     mem_rdata;
  logic            rd_valid;
  logic [7:0]      rd_data;
  logic [31:0]     latch_q;

  always #10 clk = ~clk;

  // bench cfg packing: [0] packed [1] host_oe [2] pair_clr [3] dword
  // [4] byte_mode [5] cmp_mode [7:6] map_sel [11:8] cmp_val [15:12] care
  vplane_rd #(.HOST_AW(HAW), .MEM_WORDS(WORDS)) i_vplane_rd (
    .clk (clk), .rst (rst), .host_req (host_req), .host_addr (host_addr),
    .cfg_packed (cfg[0]), .cfg_host_oe (cfg[1]), .cfg_pair_clr (cfg[2]),
    .cfg_dword (cfg[3]), .cfg_byte_mode (cfg[4]), .cfg_cmp_mode (cfg[5]),
    .cfg_map_sel (cfg[7:6]), .cfg_cmp_val (cfg[11:8]),
    .cfg_cmp_care (cfg[15:12]),
    .mem_rd_en (mem_rd_en), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
    .rd_valid (rd_valid), .rd_data (rd_data), .latch_q (latch_q)
  );

  logic [31:0] vram [WORDS];
  initial begin
    for (int i = 0; i < WORDS; i++) vram[i] = 32'(i * 32'h0102_0305 + 32'h1F2E_3D4C);
    vram[20] = 32'h0F33_55F0;
  end
  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= vram[mem_addr];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic        pv = 0;
  logic [7:0]  pd = '0;
  logic        pld = 0;
  logic [31:0] pword = '0;
  logic [31:0] mlatch = '0;
  string       ptag = "";

  function automatic logic [15:0] mk(input bit pk, input bit hoe, input bit pc,
      input bit dw, input bit bm, input bit cm, input int ms, input int cv, input int care);
    return {4'(care), 4'(cv), 2'(ms), cm, bm, dw, pc, hoe, pk};
  endfunction

  task automatic model(input int addr, input logic [15:0] c,
      output logic [7:0] d, output logic ld, output logic [31:0] w);
    int a, pl, acc, b;
    a = addr; ld = 0; w = '0;
    if (c[0]) begin pl = a % 4; a = a - (a % 4); end
    else if (c[1]) pl = (c[7:6] & 2) | (a & 1);
    else pl = c[7:6];
    if (c[2]) a = a & ~1;
    if (c[3]) a = a / 4;
    else if (c[1] && !c[4]) a = a / 2;
    if (a >= WORDS) begin d = 8'hFF; return; end
    w = vram[a];
    if (c[0] || !c[5]) d = 8'((w >> (8 * pl)) & 32'hFF);
    else begin
      acc = 0;
      for (int p = 0; p < 4; p++) begin
        b = int'((w >> (8 * p)) & 32'hFF);
        if (c[8 + p]) b = b ^ 8'hFF;
        if (!c[12 + p]) b = 0;
        acc = acc | b;
      end
      d = 8'(~acc);
    end
    ld = !c[0];
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
      input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit req, input int addr, input logic [15:0] c, input string tag);
    @(negedge clk);
    chk(rd_valid == pv, "R11", {"valid ", ptag}, 32'(rd_valid), 32'(pv));
    if (pv) chk(rd_data == pd, ptag, "data", 32'(rd_data), 32'(pd));
    chk(latch_q == mlatch, "R8", {"latch ", ptag}, latch_q, mlatch);
    if (pld) mlatch = pword;
    host_req  = req;
    host_addr = HAW'(addr);
    cfg       = c;
    pv = req; ptag = tag; pld = 0;
    if (req) model(addr, c, pd, pld, pword);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    chk(rd_valid == 1'b0, "R12", "valid after reset", 32'(rd_valid), 0);
    chk(latch_q == 32'h0, "R12", "latch after reset", latch_q, 0);

    // R3 / R9: plane from map select, byte lanes
    for (int m = 0; m < 4; m++) step(1, 5, mk(0,0,0,0,1,0,m,0,0), "R9");
    // R1 / R7: packed pixel addressing, latch untouched
    for (int i = 0; i < 8; i++) step(1, 64 + i, mk(1,0,0,0,1,1,0,0,0), "R7");
    step(1, 12'h101, mk(1,0,0,1,1,0,0,0,0), "R1");
    // R2 / R5: host odd/even plane and word shift
    step(1, 7, mk(0,1,0,0,0,0,2,0,0), "R2");
    step(1, 6, mk(0,1,0,0,0,0,0,0,0), "R2");
    step(1, 9, mk(0,1,0,0,1,0,2,0,0), "R5");
    // R4: pair clear
    step(1, 13, mk(0,1,1,0,1,0,0,0,0), "R4");
    step(1, 13, mk(0,0,1,0,1,0,1,0,0), "R4");
    // R5: doubleword beats word shift
    step(1, 83, mk(0,1,0,1,0,0,1,0,0), "R5");
    // R6: out of range, then packed read back to back
    step(1, 16383, mk(0,0,0,0,1,0,0,0,0), "R6");
    step(1, 4095, mk(0,1,0,0,0,0,0,0,0), "R6");
    step(1, 3, mk(1,0,0,0,1,0,0,0,0), "R7");
    // R10: colour compare on word 20 = 0F3355F0
    step(1, 20, mk(0,0,0,0,1,1,0,4'h0,4'hF), "R10");
    step(1, 20, mk(0,0,0,0,1,1,0,4'hF,4'hF), "R10");
    step(1, 20, mk(0,0,0,0,1,1,0,4'h5,4'h6), "R10");
    step(1, 20, mk(0,0,0,0,1,1,0,4'hA,4'h0), "R10");
    step(0, 0, '0, "R11");
    // R11: random back-to-back stream with idle gaps
    for (int i = 0; i < 300; i++)
      step(($urandom % 5) != 0, int'($urandom % 16384), 16'($urandom), "R11");
    step(0, 0, '0, "R11");
    step(0, 0, '0, "R11");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule